// File: doc/BRIEF.md
# I2C Byte-Level Bus Master

This block is the byte engine of a single-master I2C controller. A host hands it one command at a time over a valid/ready handshake. The commands are START, which also serves as a repeated START when the bus is already held, write byte, read byte with a last-byte flag, and STOP. The block drives both bus lines as open-drain outputs. Each line has a pull-low enable and a sampled input. SCL timing comes from a programmable quarter-period divider.

Every byte takes nine SCL pulses, and the master generates all of them. The ninth pulse is treated as a handshake whose direction depends on the transfer. When the master writes, it lets go of SDA on the ninth pulse and reads the slave's answer. When the master reads, it answers on the ninth pulse: a low level for every byte except the last, and a high level on the last byte to mark the end of data. A slave that does not acknowledge a written byte puts the engine into an error state. In that state the engine refuses further byte commands, so the host's only ways forward are STOP or a repeated START.

Between commands the engine is idle. It either holds SCL low, with the bus still owned after a START or a byte, or it leaves both lines released after a STOP.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both line enables are low (lines released), `cmd_ready` is 1, `ack_error` is 0 and `rd_data` is 0.
- R2: `cmd_code` 1 (START) releases SDA, then releases SCL, then pulls SDA low while SCL is high, then pulls SCL low. The result is a START from a free bus or a repeated START from a held bus, and afterwards the bus is held with SCL low. START is always accepted.
- R3: `cmd_code` 2 (write) shifts out `wr_data` MSB first over eight SCL pulses. SDA changes only while SCL is low.
- R4: On the ninth pulse of a write, SDA stays released for the whole time SCL is high. The SDA level sampled there is presented on `ack_bit` (0 = acknowledge, 1 = not-acknowledge).
- R5: A not-acknowledge on a write sets `ack_error`. The flag stays set through STOP and is cleared only when a START command is accepted.
- R6: A write or read (`cmd_code` 2 or 3) issued while `ack_error` is set, or while the bus is free, is consumed with no line activity. `cmd_ready` stays 1 and `rd_data` is unchanged. A STOP (`cmd_code` 4) on a free bus is also a no-op. Codes 0, 5, 6 and 7 do nothing.
- R7: `cmd_code` 3 (read) samples SDA at the middle of each SCL high phase, MSB first. The byte appears on `rd_data` when `cmd_ready` returns.
- R8: On the ninth pulse of a read the master drives SDA low when `cmd_last` was 0 and leaves it released when `cmd_last` was 1.
- R9: `cmd_code` 4 (STOP) on a held bus pulls SDA low, releases SCL, then releases SDA while SCL is high. Both lines are left released.
- R10: Each quarter of an SCL period lasts `div_cfg`+1 clocks, so SCL is high for 2·(`div_cfg`+1) clocks per pulse.
- R11: `cmd_ready` is 0 from the cycle after a bus command is accepted until that command finishes. While idle, neither line enable changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_cfg | input | DIV_W | Quarter-period length minus one, in clocks |
| cmd_valid | input | 1 | Host presents a command |
| cmd_code | input | 3 | 1 START, 2 write, 3 read, 4 STOP |
| cmd_last | input | 1 | Read only: this is the final byte (answer with not-acknowledge) |
| wr_data | input | DATA_W | Byte to transmit |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| rd_data | output | DATA_W | Last byte received |
| ack_bit | output | 1 | SDA level sampled on the last ninth pulse |
| ack_error | output | 1 | A written byte was not acknowledged |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
Several properties are checked on every cycle. SDA stays frozen while SCL is released during a byte. SDA is released on the ninth pulse of a write and follows the last-byte flag on the ninth pulse of a read. The error flag persists until a START is accepted. A refused command leaves the lines and the ready signal untouched. Both line enables stay steady while the engine is idle. Only the bench scenarios can show the things that need a slave on the wire: that the decoded bus carries the right START/STOP ordering and bit order, that read data lands on `rd_data`, that a slave's not-acknowledge reaches `ack_bit`, and that SCL high time scales with the divider.

// File: rtl/i2c_bm_pkg.sv
// Shared command codes and controller state encoding for the I2C byte master.
// Assumes a 3-bit command field on the host side.
package i2c_bm_pkg;

    localparam logic [2:0] CMD_START = 3'd1;
    localparam logic [2:0] CMD_WRITE = 3'd2;
    localparam logic [2:0] CMD_READ  = 3'd3;
    localparam logic [2:0] CMD_STOP  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BYTE,
        ST_STOP
    } bm_state_t;

endpackage

// File: rtl/i2c_bm_qtick.sv
// Quarter-period timer: emits a one-cycle tick every div_cfg+1 enabled clocks.
// Assumes div_cfg is held steady while the timer is running; clr restarts it.
module i2c_bm_qtick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Tick fires on the last enabled clock of a quarter.
    assign tick = en && (cnt == div_cfg);

    // Count enabled clocks, wrapping at the programmed limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/i2c_bm_shreg.sv
// MSB-first shift register shared by transmit and receive.
// Assumes load and shift are never asserted in the same cycle.
module i2c_bm_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] data,
    output logic         msb
);

    assign msb = data[W-1];

    // Load a fresh byte or move one bit toward the MSB, filling from ser_in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (load) begin
            data <= load_val;
        end else if (shift) begin
            data <= {data[W-2:0], ser_in};
        end
    end

endmodule

// File: rtl/i2c_byte_master.sv
// I2C byte-level master. Runs one host command at a time: START/repeated
// START, write byte, read byte, STOP. Every bit is four quarters: SCL low,
// SCL low (SDA updated on entry), SCL high, SCL high (SDA sampled on entry,
// i.e. mid high phase). The ninth bit carries the acknowledge in the
// direction set by the command. Assumes a single master; the high-phase
// quarters only advance once SCL reads back high.
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic              cmd_last,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cmd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack_bit,
    output logic              ack_error,
    input  logic              scl_in,
    output logic              scl_oe,
    input  logic              sda_in,
    output logic              sda_oe
);

    localparam int              BIT_W    = $clog2(DATA_W + 1);
    localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(DATA_W);

    bm_state_t          state;
    logic [1:0]         quarter;
    logic [BIT_W-1:0]   bit_idx;
    logic               rd_mode;
    logic               last_flag;
    logic               bus_held;
    logic               tick;
    logic               tmr_en;
    logic               sh_load;
    logic               sh_shift;
    logic [DATA_W-1:0]  sh_data;
    logic               sh_msb;
    logic               byte_ok;
    logic               at_ack;

    assign cmd_ready = (state == ST_IDLE);
    assign at_ack    = (bit_idx == ACK_SLOT);
    assign byte_ok   = bus_held && !ack_error;

    // Timer runs while busy; high quarters wait for SCL to read high.
    assign tmr_en = (state != ST_IDLE) && !(quarter[1] && !scl_oe && !scl_in);

    // Load shift register on accepted byte commands; shift at each data sample.
    assign sh_load  = cmd_ready && cmd_valid && byte_ok &&
                      (cmd_code == CMD_WRITE || cmd_code == CMD_READ);
    assign sh_shift = (state == ST_BYTE) && tick && (quarter == 2'd2) && !at_ack;

    i2c_bm_qtick #(.DIV_W(DIV_W)) u_qtick (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cmd_ready),
        .en      (tmr_en),
        .div_cfg (div_cfg),
        .tick    (tick)
    );

    i2c_bm_shreg #(.W(DATA_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val ((cmd_code == CMD_READ) ? {DATA_W{1'b1}} : wr_data),
        .shift    (sh_shift),
        .ser_in   (sda_in),
        .data     (sh_data),
        .msb      (sh_msb)
    );

    // Command sequencer: accepts commands and steps line enables per quarter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            quarter   <= 2'd0;
            bit_idx   <= '0;
            rd_mode   <= 1'b0;
            last_flag <= 1'b0;
            bus_held  <= 1'b0;
            scl_oe    <= 1'b0;
            sda_oe    <= 1'b0;
            ack_bit   <= 1'b0;
            ack_error <= 1'b0;
            rd_data   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        quarter <= 2'd0;
                        bit_idx <= '0;
                        case (cmd_code)
                            CMD_START: begin
                                state     <= ST_START;
                                ack_error <= 1'b0;
                            end
                            CMD_WRITE: begin
                                if (byte_ok) begin
                                    state   <= ST_BYTE;
                                    rd_mode <= 1'b0;
                                end
                            end
                            CMD_READ: begin
                                if (byte_ok) begin
                                    state     <= ST_BYTE;
                                    rd_mode   <= 1'b1;
                                    last_flag <= cmd_last;
                                end
                            end
                            CMD_STOP: begin
                                if (bus_held) begin
                                    state <= ST_STOP;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_START: begin
                    if (tick) begin
                        quarter <= quarter + 2'd1;
                        case (quarter)
                            2'd0: sda_oe <= 1'b0;
                            2'd1: scl_oe <= 1'b0;
                            2'd2: sda_oe <= 1'b1;
                            default: begin
                                scl_oe   <= 1'b1;
                                bus_held <= 1'b1;
                                state    <= ST_IDLE;
                            end
                        endcase
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        quarter <= quarter + 2'd1;
                        case (quarter)
                            2'd0: sda_oe <= 1'b1;
                            2'd1: scl_oe <= 1'b0;
                            2'd2: sda_oe <= 1'b0;
                            default: begin
                                bus_held <= 1'b0;
                                state    <= ST_IDLE;
                            end
                        endcase
                    end
                end
                ST_BYTE: begin
                    if (tick) begin
                        quarter <= quarter + 2'd1;
                        case (quarter)
                            2'd0: begin
                                if (at_ack) begin
                                    sda_oe <= rd_mode && !last_flag;
                                end else begin
                                    sda_oe <= !rd_mode && !sh_msb;
                                end
                            end
                            2'd1: scl_oe <= 1'b0;
                            2'd2: begin
                                if (at_ack) begin
                                    ack_bit <= sda_in;
                                    if (!rd_mode && sda_in) begin
                                        ack_error <= 1'b1;
                                    end
                                end
                            end
                            default: begin
                                scl_oe <= 1'b1;
                                if (at_ack) begin
                                    state <= ST_IDLE;
                                    if (rd_mode) begin
                                        rd_data <= sh_data;
                                    end
                                end else begin
                                    bit_idx <= bit_idx + BIT_W'(1);
                                end
                            end
                        endcase
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2c_byte_master_chk.sv
// Protocol checker for i2c_byte_master, attached by bind.
// Assumes the enables are 1 for "pull low".
module i2c_byte_master_chk
    import i2c_bm_pkg::*;
#(
    parameter int BIT_W    = 4,
    parameter int ACK_SLOT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_code,
    input logic             ack_error,
    input logic             scl_oe,
    input logic             sda_oe,
    input bm_state_t        state,
    input logic [BIT_W-1:0] bit_idx,
    input logic             rd_mode,
    input logic             last_flag
);

    logic on_ack;
    assign on_ack = (state == ST_BYTE) && (bit_idx == BIT_W'(ACK_SLOT));

    // R3: inside a byte, SDA never moves while SCL stays released.
    assert_sda_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYTE && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

    // R4: master lets go of SDA during the high part of a write's ninth pulse.
    assert_wr_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (on_ack && !rd_mode && !scl_oe) |-> !sda_oe);

    // R8: master answers a read according to the last-byte flag.
    assert_rd_ack_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (on_ack && rd_mode && !scl_oe) |-> (sda_oe == !last_flag));

    // R5: the error flag persists unless a START was accepted.
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack_error) && !$past(cmd_valid && cmd_ready && cmd_code == CMD_START))
        |-> ack_error);

    // R6: refused byte commands leave lines and handshake untouched.
    assert_refuse_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && ack_error &&
         (cmd_code == CMD_WRITE || cmd_code == CMD_READ))
        |=> (cmd_ready && $stable(scl_oe) && $stable(sda_oe)));

    // R11: line enables hold still while idle with no command offered.
    assert_idle_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !cmd_valid) |=> ($stable(scl_oe) && $stable(sda_oe)));

endmodule

bind i2c_byte_master i2c_byte_master_chk #(
    .BIT_W    (BIT_W),
    .ACK_SLOT (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_code  (cmd_code),
    .ack_error (ack_error),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .state     (state),
    .bit_idx   (bit_idx),
    .rd_mode   (rd_mode),
    .last_flag (last_flag)
);

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected bus events, a monitor decodes
// START, STOP and 9-bit bytes off the wires and compares. A small slave model
// answers writes and supplies read data.
module i2c_byte_master_bench;

    localparam int DIV_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [DIV_W-1:0] div_cfg = 16'd3;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic        cmd_last = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        cmd_ready;
    logic [7:0]  rd_data;
    logic        ack_bit;
    logic        ack_error;
    logic        scl_oe, sda_oe, scl_in, sda_in;
    logic        slave_pull;

    // Slave model state
    logic        s_active = 1'b0, s_fresh = 1'b0, s_quiet = 1'b0;
    int          s_idx = 0;
    logic        s_rd = 1'b0, s_ack = 1'b1;
    logic [7:0]  s_tx = 8'h00;

    always #2.5 clk = ~clk;

    assign scl_in = !scl_oe;
    assign sda_in = !(sda_oe || slave_pull);
    assign slave_pull = s_active && (s_rd ? (!s_quiet && s_idx < 8 && !s_tx[7 - s_idx])
                                          : (s_idx == 8 && s_ack));

    i2c_byte_master #(.DIV_W(DIV_W), .DATA_W(8)) u_i2c_byte_master (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_last(cmd_last),
        .wr_data(wr_data), .cmd_ready(cmd_ready), .rd_data(rd_data),
        .ack_bit(ack_bit), .ack_error(ack_error),
        .scl_in(scl_in), .scl_oe(scl_oe), .sda_in(sda_in), .sda_oe(sda_oe)
    );

    typedef struct { int kind; logic [7:0] data; logic ack; } ev_t;
    ev_t exp_q[$];
    int  n_chk = 0, n_fail = 0;
    bit  done = 0;

    function automatic void chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    function automatic void push_ev(int k, logic [7:0] d, logic a);
        ev_t e;
        e.kind = k; e.data = d; e.ack = a;
        exp_q.push_back(e);
    endfunction

    // Compare one decoded bus event against the head of the queue.
    function automatic void got_ev(int k, logic [7:0] d, logic a);
        ev_t e;
        string req;
        req = (k == 0) ? "R2" : (k == 1) ? "R9" : "R3";
        if (exp_q.size() == 0) begin
            chk(1'b0, req, "unexpected bus event", (k << 12) | (int'(d) << 4) | int'(a), 0);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == k && (k != 2 || (e.data == d && e.ack == a)), req, "bus event",
                (k << 12) | (int'(d) << 4) | int'(a),
                (e.kind << 12) | (int'(e.data) << 4) | int'(e.ack));
        end
    endfunction

    // Monitor and slave: decode line activity away from the active edge.
    logic pscl = 1'b1, psda = 1'b1;
    int   bcnt = 0, cyc = 0, rise_cyc = 0, high_w = 0;
    logic [7:0] bsh = 8'h00;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (scl_in && pscl && sda_in != psda) begin
                if (!sda_in) begin
                    got_ev(0, 8'h00, 1'b0);
                    bcnt = 0; s_active = 1'b1; s_fresh = 1'b1; s_idx = 0; s_quiet = 1'b0;
                end else begin
                    got_ev(1, 8'h00, 1'b0);
                    s_active = 1'b0;
                end
            end
            if (scl_in && !pscl) begin
                rise_cyc = cyc;
                if (s_active && s_rd && s_idx == 8 && sda_in) s_quiet = 1'b1;
                if (bcnt < 8) bsh = {bsh[6:0], sda_in};
                else got_ev(2, bsh, sda_in);
                bcnt = (bcnt == 8) ? 0 : bcnt + 1;
            end
            if (!scl_in && pscl) begin
                high_w = cyc - rise_cyc;
                if (s_fresh) s_fresh = 1'b0;
                else s_idx = (s_idx == 8) ? 0 : s_idx + 1;
            end
        end
        pscl = scl_in;
        psda = sda_in;
    end

    // Driver: offer one command, then wait for the engine to come back idle.
    task automatic run_cmd(input logic [2:0] code, input logic last,
                           input logic [7:0] d, input bit expect_busy);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_last = last; wr_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (expect_busy) chk(cmd_ready == 1'b0, "R11", "ready low while busy", cmd_ready, 0);
        else chk(cmd_ready == 1'b1, "R6", "ready stays high on refused command", cmd_ready, 1);
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic s_scl, s_sda;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(scl_oe == 0 && sda_oe == 0, "R1", "lines released", {scl_oe, sda_oe}, 0);
        chk(cmd_ready == 1, "R1", "ready", cmd_ready, 1);
        chk(ack_error == 0 && rd_data == 8'h00, "R1", "flags/data", {ack_error, rd_data}, 0);

        // R6: byte command on a free bus does nothing
        run_cmd(3'd2, 1'b0, 8'h12, 1'b0);
        repeat (20) @(negedge clk);
        chk(scl_oe == 0 && sda_oe == 0, "R6", "free-bus write quiet", {scl_oe, sda_oe}, 0);

        // R2 START, bus held afterwards
        push_ev(0, 8'h00, 1'b0);
        run_cmd(3'd1, 1'b0, 8'h00, 1'b1);
        chk(scl_oe == 1 && sda_oe == 1, "R2", "bus held after START", {scl_oe, sda_oe}, 3);

        // R11 idle lines stable
        s_scl = scl_oe; s_sda = sda_oe;
        repeat (12) @(negedge clk);
        chk(scl_oe == s_scl && sda_oe == s_sda, "R11", "idle lines", {scl_oe, sda_oe}, {s_scl, s_sda});

        // R3/R4 write with acknowledge, R10 timing
        s_rd = 1'b0; s_ack = 1'b1;
        push_ev(2, 8'hA5, 1'b0);
        run_cmd(3'd2, 1'b0, 8'hA5, 1'b1);
        chk(ack_bit == 0, "R4", "ack sampled", ack_bit, 0);
        chk(ack_error == 0, "R5", "no error after ACK", ack_error, 0);
        chk(high_w == 8, "R10", "SCL high width div=3", high_w, 8);

        // R7/R8 read not last, then last
        s_rd = 1'b1; s_tx = 8'h3C;
        push_ev(2, 8'h3C, 1'b0);
        run_cmd(3'd3, 1'b0, 8'h00, 1'b1);
        chk(rd_data == 8'h3C, "R7", "read byte", rd_data, 8'h3C);
        s_tx = 8'hC3;
        push_ev(2, 8'hC3, 1'b1);
        run_cmd(3'd3, 1'b1, 8'h00, 1'b1);
        chk(rd_data == 8'hC3, "R7", "read last byte", rd_data, 8'hC3);
        chk(ack_bit == 1, "R8", "last byte answered high", ack_bit, 1);

        // R2 repeated START, then R5 NACK on write
        s_rd = 1'b0; s_ack = 1'b0;
        push_ev(0, 8'h00, 1'b0);
        run_cmd(3'd1, 1'b0, 8'h00, 1'b1);
        push_ev(2, 8'h5A, 1'b1);
        run_cmd(3'd2, 1'b0, 8'h5A, 1'b1);
        chk(ack_bit == 1, "R4", "nack sampled", ack_bit, 1);
        chk(ack_error == 1, "R5", "error set on NACK", ack_error, 1);

        // R6 refused write and read while in error
        s_scl = scl_oe; s_sda = sda_oe;
        run_cmd(3'd2, 1'b0, 8'hFF, 1'b0);
        repeat (20) @(negedge clk);
        chk(scl_oe == s_scl && sda_oe == s_sda, "R6", "refused write quiet",
            {scl_oe, sda_oe}, {s_scl, s_sda});
        run_cmd(3'd3, 1'b1, 8'h00, 1'b0);
        repeat (20) @(negedge clk);
        chk(rd_data == 8'hC3, "R6", "refused read keeps data", rd_data, 8'hC3);

        // R9 STOP, R5 error held through STOP
        push_ev(1, 8'h00, 1'b0);
        run_cmd(3'd4, 1'b0, 8'h00, 1'b1);
        chk(scl_oe == 0 && sda_oe == 0, "R9", "lines released after STOP", {scl_oe, sda_oe}, 0);
        chk(ack_error == 1, "R5", "error held through STOP", ack_error, 1);

        // R5 START clears error; R10 with another divider
        push_ev(0, 8'h00, 1'b0);
        run_cmd(3'd1, 1'b0, 8'h00, 1'b1);
        chk(ack_error == 0, "R5", "START clears error", ack_error, 0);
        div_cfg = 16'd1; s_ack = 1'b1;
        push_ev(2, 8'h96, 1'b0);
        run_cmd(3'd2, 1'b0, 8'h96, 1'b1);
        chk(high_w == 4, "R10", "SCL high width div=1", high_w, 4);
        push_ev(1, 8'h00, 1'b0);
        run_cmd(3'd4, 1'b0, 8'h00, 1'b1);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "all expected events seen", exp_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end

endmodule